// File: doc/BRIEF.md
# Multiply-Accumulate Arithmetic Core with Saturation

This block is the datapath of a multiply-accumulate engine that holds four 48-bit accumulators. In one registered stage it multiplies two 32-bit operands, classifies the product for overflow, adds the product to (or subtracts it from) one selected accumulator, and then applies the saturation rule of the active number format. Three formats are supported: signed integer, unsigned integer and fractional. A saturation enable chooses between clamping and wrapping, and a rounding enable controls how fractional products are reduced.

The overflow handling is deliberately asymmetric. A product that overflows under saturation is replaced by a large constant, so the accumulation that follows is certain to overflow and clamp. Signed-integer overflow is detected at the 48-bit accumulator width, but the value is clamped to the 32-bit integer limits. Overflow leaves two kinds of sticky record: a global overflow flag that a clear request resets, and one flag per accumulator that only a reload of that accumulator resets. A status port reports zero, negative and sticky overflow for any accumulator.

Top module: `mac_sat_core`

## Requirements
- R1: With op_mode 0 (signed integer; code 3 behaves the same) the product is the full signed 64-bit product. It overflows when it is not the sign extension of its low 40 bits. Under sat_en an overflowing product is replaced by +2^50 if non-negative, or by the bitwise complement of 2^50 if negative.
- R2: With op_mode 1 (unsigned integer) the product overflows when any bit at position 40 or above is set. An overflowing product becomes 2^50 under sat_en and is cut to its low 40 bits otherwise.
- R3: With op_mode 2 (fractional) the signed product is shifted right arithmetically by 24 and never flags overflow. With round_en, a discarded part above 0x800000 rounds up, and exactly 0x800000 rounds to the even neighbour. Without round_en the discarded part is dropped.
- R4: An accepted operation replaces accumulator op_acc with accumulator + product, or accumulator − product when op_sub is 1. The accumulator is zero-extended in unsigned mode and sign-extended otherwise. The result is visible on the clock edge that accepts the operation.
- R5: In signed-integer mode the sum overflows when it does not fit 48 signed bits. Under sat_en an overflowing result becomes 0x0000_7FFF_FFFF, or 0xFFFF_8000_0000 if the sum is negative. Otherwise the low 48 bits are kept.
- R6: In fractional mode the overflow test is the same as in R5, but sat_en clamps to 0x7FFF_FFFF_FFFF, or 0x8000_0000_0000 for a negative sum.
- R7: In unsigned mode the sum overflows when any bit at position 48 or above is set. Under sat_en the result becomes 0 if the 64-bit sum, read as unsigned, exceeds 2^53, and 2^48 − 1 otherwise. Without sat_en the low 48 bits are kept.
- R8: An operation whose product or sum overflows sets ovf and pav[op_acc]. ovf_clr clears ovf, but an overflow in the same cycle wins. A set pav bit holds until its accumulator is loaded.
- R9: load_valid writes load_data into accumulator load_acc and clears pav[load_acc]. When the load and an operation target the same accumulator, the load wins and the operation has no effect at all. An operation on a different accumulator proceeds normally.
- R10: st_zero is 1 when accumulator stat_sel is 0, st_neg equals its bit 47, and st_ovf equals pav[stat_sel]. acc_flat carries accumulator i in bits [48i+47:48i].
- R11: After reset all accumulators, pav and ovf are 0.
- R12: A cycle with neither an operation nor a load leaves every accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_sub | input | 1 | 1 = subtract the product, 0 = add it |
| op_acc | input | 2 | Target accumulator |
| op_mode | input | 2 | 0 signed integer, 1 unsigned integer, 2 fractional |
| sat_en | input | 1 | Saturate on overflow |
| round_en | input | 1 | Round fractional products half-to-even |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| load_valid | input | 1 | Accumulator reload request |
| load_acc | input | 2 | Accumulator to reload |
| load_data | input | 48 | Reload value |
| ovf_clr | input | 1 | Clear the global overflow flag |
| stat_sel | input | 2 | Accumulator reported on the status outputs |
| acc_flat | output | 192 | All accumulators, packed |
| ovf | output | 1 | Sticky global overflow |
| pav | output | 4 | Sticky per-accumulator overflow |
| st_zero | output | 1 | Selected accumulator is zero |
| st_neg | output | 1 | Selected accumulator bit 47 |
| st_ovf | output | 1 | pav bit of the selected accumulator |

## Verification
The bench targets the places where the overflow rules differ by format. It forces product overflow under saturation, where a design that skipped the 2^50 substitution would wrap instead of clamping. It checks the signed clamp at the 32-bit limit, which a design using the 48-bit limit would miss. It checks the unsigned subtraction that underflows to zero, which a design that kept a plain all-ones clamp would get wrong. Fractional rounding is exercised at exactly half with odd and even quotients, where rounding half-up would be off by one. It also drives a load and an operation to the same accumulator, and an overflow in the same cycle as a flag clear, where the wrong priority shows up as a wrong accumulator value or a lost flag.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;
   typedef enum logic [1:0] {
      MODE_SINT = 2'd0,
      MODE_UINT = 2'd1,
      MODE_FRAC = 2'd2,
      MODE_RSVD = 2'd3
   } mac_mode_e;
endpackage

// File: rtl/mac_sat_product.sv
module mac_sat_product
   import mac_sat_pkg::*;
#(
   parameter int OPW       = 32,
   parameter int KEEPW     = 40,
   parameter int FSHIFT    = 24,
   parameter int FORCE_BIT = 50,
   localparam int PW       = 2 * OPW
) (
   input  logic [OPW-1:0] a_i,
   input  logic [OPW-1:0] b_i,
   input  mac_mode_e      mode_i,
   input  logic           omc_i,
   input  logic           rt_i,
   output logic [PW-1:0]  prod_o,
   output logic           ovf_o
);
   localparam logic [PW-1:0]     ONE       = {{(PW-1){1'b0}}, 1'b1};
   localparam logic [PW-1:0]     FORCE_POS = ONE << FORCE_BIT;
   localparam logic [FSHIFT-1:0] HALF      = {1'b1, {(FSHIFT-1){1'b0}}};

   logic signed [PW-1:0] sprod;
   logic        [PW-1:0] uprod;
   logic signed [PW-1:0] quo;
   logic [FSHIFT-1:0]    rem;
   logic                 bump;
   logic                 sint_fit;
   logic                 uint_fit;

   assign sprod    = $signed({{OPW{a_i[OPW-1]}}, a_i}) * $signed({{OPW{b_i[OPW-1]}}, b_i});
   assign uprod    = {{OPW{1'b0}}, a_i} * {{OPW{1'b0}}, b_i};
   assign sint_fit = (sprod == {{(PW-KEEPW){sprod[KEEPW-1]}}, sprod[KEEPW-1:0]});
   assign uint_fit = ~|uprod[PW-1:KEEPW];
   assign quo      = sprod >>> FSHIFT;
   assign rem      = sprod[FSHIFT-1:0];
   assign bump     = rt_i & ((rem > HALF) | ((rem == HALF) & quo[0]));

   always_comb begin
      case (mode_i)
         MODE_UINT: begin
            ovf_o = ~uint_fit;
            if (uint_fit)   prod_o = uprod;
            else if (omc_i) prod_o = FORCE_POS;
            else            prod_o = {{(PW-KEEPW){1'b0}}, uprod[KEEPW-1:0]};
         end
         MODE_FRAC: begin
            ovf_o  = 1'b0;
            prod_o = quo + {{(PW-1){1'b0}}, bump};
         end
         default: begin
            ovf_o = ~sint_fit;
            if (!sint_fit && omc_i) prod_o = sprod[PW-1] ? ~FORCE_POS : FORCE_POS;
            else                    prod_o = sprod;
         end
      endcase
   end
endmodule

// File: rtl/mac_sat_accum.sv
module mac_sat_accum
   import mac_sat_pkg::*;
#(
   parameter int ACCW     = 48,
   parameter int OPW      = 32,
   parameter int PW       = 64,
   parameter int ZERO_BIT = 53
) (
   input  logic [ACCW-1:0] acc_i,
   input  logic [PW-1:0]   prod_i,
   input  logic            sub_i,
   input  mac_mode_e       mode_i,
   input  logic            omc_i,
   input  logic            prod_ovf_i,
   output logic [ACCW-1:0] acc_o,
   output logic            ovf_o
);
   localparam logic [ACCW-1:0] SINT_MAX = {{(ACCW-OPW+1){1'b0}}, {(OPW-1){1'b1}}};
   localparam logic [ACCW-1:0] FRAC_MAX = {1'b0, {(ACCW-1){1'b1}}};
   localparam logic [PW-1:0]   ZERO_LIM = {{(PW-1){1'b0}}, 1'b1} << ZERO_BIT;

   logic [PW-1:0] ext;
   logic [PW-1:0] sum;
   logic          fit;

   assign ext = (mode_i == MODE_UINT) ? {{(PW-ACCW){1'b0}}, acc_i}
                                      : {{(PW-ACCW){acc_i[ACCW-1]}}, acc_i};
   assign sum = sub_i ? (ext - prod_i) : (ext + prod_i);

   always_comb begin
      if (mode_i == MODE_UINT) fit = ~|sum[PW-1:ACCW];
      else                     fit = (&sum[PW-1:ACCW-1]) | ~(|sum[PW-1:ACCW-1]);
      ovf_o = prod_ovf_i | ~fit;
      acc_o = sum[ACCW-1:0];
      if (ovf_o && omc_i) begin
         case (mode_i)
            MODE_UINT: acc_o = (sum > ZERO_LIM) ? '0 : '1;
            MODE_FRAC: acc_o = sum[PW-1] ? ~FRAC_MAX : FRAC_MAX;
            default:   acc_o = sum[PW-1] ? ~SINT_MAX : SINT_MAX;
         endcase
      end
   end
endmodule

// File: rtl/mac_sat_core.sv
module mac_sat_core
   import mac_sat_pkg::*;
#(
   parameter int OPW    = 32,
   parameter int ACCW   = 48,
   parameter int NACC   = 4,
   parameter int KEEPW  = 40,
   parameter int FSHIFT = 24,
   localparam int AW    = $clog2(NACC),
   localparam int PW    = 2 * OPW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic                 op_sub,
   input  logic [AW-1:0]        op_acc,
   input  logic [1:0]           op_mode,
   input  logic                 sat_en,
   input  logic                 round_en,
   input  logic [OPW-1:0]       op_a,
   input  logic [OPW-1:0]       op_b,
   input  logic                 load_valid,
   input  logic [AW-1:0]        load_acc,
   input  logic [ACCW-1:0]      load_data,
   input  logic                 ovf_clr,
   input  logic [AW-1:0]        stat_sel,
   output logic [NACC*ACCW-1:0] acc_flat,
   output logic                 ovf,
   output logic [NACC-1:0]      pav,
   output logic                 st_zero,
   output logic                 st_neg,
   output logic                 st_ovf
);
   localparam int FORCE_BIT = ACCW + 2;
   localparam int ZERO_BIT  = ACCW + 5;

   if (NACC < 2 || NACC != (1 << AW)) begin : g_chk_nacc
      $error("NACC must be a power of two, at least 2");
   end
   if (ZERO_BIT >= PW || KEEPW >= PW || OPW > ACCW) begin : g_chk_width
      $error("product width too small for the accumulator limits");
   end
   if (FSHIFT < 1 || FSHIFT >= KEEPW) begin : g_chk_shift
      $error("fractional shift out of range");
   end

   mac_mode_e       mode;
   logic [ACCW-1:0] acc_q [NACC];
   logic [PW-1:0]   prod;
   logic            prod_ovf;
   logic [ACCW-1:0] sat_acc;
   logic            sat_ovf;
   logic            op_hit;
   logic            ovf_q;

   assign mode   = mac_mode_e'(op_mode);
   assign op_hit = op_valid & ~(load_valid & (load_acc == op_acc));

   mac_sat_product #(
      .OPW(OPW), .KEEPW(KEEPW), .FSHIFT(FSHIFT), .FORCE_BIT(FORCE_BIT)
   ) i_product (
      .a_i(op_a), .b_i(op_b), .mode_i(mode), .omc_i(sat_en), .rt_i(round_en),
      .prod_o(prod), .ovf_o(prod_ovf)
   );

   mac_sat_accum #(
      .ACCW(ACCW), .OPW(OPW), .PW(PW), .ZERO_BIT(ZERO_BIT)
   ) i_accum (
      .acc_i(acc_q[op_acc]), .prod_i(prod), .sub_i(op_sub), .mode_i(mode),
      .omc_i(sat_en), .prod_ovf_i(prod_ovf), .acc_o(sat_acc), .ovf_o(sat_ovf)
   );

   for (genvar g = 0; g < NACC; g++) begin : g_acc
      logic [ACCW-1:0] acc_r;
      logic            pav_r;
      logic            ld_hit;
      logic            op_wr;

      assign ld_hit = load_valid && (load_acc == AW'(g));
      assign op_wr  = op_hit && (op_acc == AW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_r <= '0;
            pav_r <= 1'b0;
         end else if (ld_hit) begin
            acc_r <= load_data;
            pav_r <= 1'b0;
         end else if (op_wr) begin
            acc_r <= sat_acc;
            pav_r <= pav_r | sat_ovf;
         end
      end

      assign acc_q[g]                = acc_r;
      assign pav[g]                  = pav_r;
      assign acc_flat[g*ACCW +: ACCW] = acc_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q <= 1'b0;
      else        ovf_q <= (ovf_q & ~ovf_clr) | (op_hit & sat_ovf);
   end

   assign ovf     = ovf_q;
   assign st_zero = (acc_q[stat_sel] == '0);
   assign st_neg  = acc_q[stat_sel][ACCW-1];
   assign st_ovf  = pav[stat_sel];
endmodule

// File: rtl/mac_sat_core_chk.sv
module mac_sat_core_chk #(
   parameter int ACCW = 48,
   parameter int NACC = 4,
   localparam int AW  = $clog2(NACC)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 op_valid,
   input logic                 load_valid,
   input logic [AW-1:0]        load_acc,
   input logic [ACCW-1:0]      load_data,
   input logic                 ovf_clr,
   input logic [NACC*ACCW-1:0] acc_flat,
   input logic                 ovf,
   input logic [NACC-1:0]      pav
);
   AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);  // R8

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !load_valid) |=> $stable(acc_flat));  // R12

   for (genvar i = 0; i < NACC; i++) begin : g_per_acc
      AST_PAV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (pav[i] && !(load_valid && load_acc == AW'(i))) |=> pav[i]);  // R8

      AST_PAV_WITH_OVF: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pav[i]) |-> ovf);  // R8

      AST_LOAD_CLEARS_PAV: assert property (@(posedge clk) disable iff (!rst_n)
         (load_valid && load_acc == AW'(i)) |=> !pav[i]);  // R9

      AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
         (load_valid && load_acc == AW'(i)) |=> (acc_flat[i*ACCW +: ACCW] == $past(load_data)));  // R9
   end
endmodule

bind mac_sat_core mac_sat_core_chk #(.ACCW(ACCW), .NACC(NACC)) i_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .load_valid(load_valid),
   .load_acc(load_acc), .load_data(load_data), .ovf_clr(ovf_clr),
   .acc_flat(acc_flat), .ovf(ovf), .pav(pav)
);

// File: tb/test_mac_sat_core.sv
`timescale 1ns/1ps
module test_mac_sat_core;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0, op_sub = 1'b0, sat_en = 1'b0, round_en = 1'b0;
   logic [1:0]   op_acc = '0, op_mode = '0, load_acc = '0, stat_sel = '0;
   logic [31:0]  op_a = '0, op_b = '0;
   logic         load_valid = 1'b0, ovf_clr = 1'b0;
   logic [47:0]  load_data = '0;
   logic [191:0] acc_flat;
   logic         ovf, st_zero, st_neg, st_ovf;
   logic [3:0]   pav;

   always #4 clk = ~clk;

   mac_sat_core i_mac_sat_core (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub), .op_acc(op_acc),
      .op_mode(op_mode), .sat_en(sat_en), .round_en(round_en), .op_a(op_a), .op_b(op_b),
      .load_valid(load_valid), .load_acc(load_acc), .load_data(load_data),
      .ovf_clr(ovf_clr), .stat_sel(stat_sel), .acc_flat(acc_flat), .ovf(ovf),
      .pav(pav), .st_zero(st_zero), .st_neg(st_neg), .st_ovf(st_ovf)
   );

   typedef struct {
      int           due;
      string        tag;
      logic [191:0] flat;
      logic [3:0]   pav;
      logic         ovf;
   } item_t;

   item_t       sb_q[$];
   int          cyc = 0;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          done = 0;
   logic [47:0] m_acc [4];
   logic [3:0]  m_pav = '0;
   logic        m_ovf = 1'b0;

   always @(posedge clk) cyc++;

   function automatic logic [63:0] m_prod(input logic [1:0] md, input logic [31:0] a,
                                          input logic [31:0] b, input bit omc, input bit rt,
                                          output bit pv);
      logic signed [63:0] sp;
      logic [63:0]        up;
      logic signed [63:0] q;
      logic [23:0]        rm;
      sp = 64'(signed'(a)) * 64'(signed'(b));
      up = {32'h0, a} * {32'h0, b};
      pv = 1'b0;
      if (md == 2'd1) begin
         pv = (up[63:40] != 0);
         if (pv) return omc ? (64'd1 << 50) : {24'h0, up[39:0]};
         return up;
      end else if (md == 2'd2) begin
         q  = sp >>> 24;
         rm = sp[23:0];
         if (rt && (rm > 24'h800000)) q = q + 1;
         if (rt && (rm == 24'h800000) && q[0]) q = q + 1;
         return q;
      end
      pv = (((sp <<< 24) >>> 24) != sp);
      if (pv && omc) return sp[63] ? ~(64'd1 << 50) : (64'd1 << 50);
      return sp;
   endfunction

   function automatic logic [47:0] m_sat(input logic [1:0] md, input logic [47:0] acc,
                                         input logic [63:0] p, input bit sub, input bit omc,
                                         input bit pv, output bit ov);
      logic [63:0] ext, s;
      bit          fit;
      ext = (md == 2'd1) ? {16'h0, acc} : {{16{acc[47]}}, acc};
      s   = sub ? ext - p : ext + p;
      if (md == 2'd1) fit = (s[63:48] == 0);
      else            fit = (s[63:47] == 0) || (s[63:47] == {17{1'b1}});
      ov = pv || !fit;
      if (ov && omc) begin
         if (md == 2'd1) return (s > (64'd1 << 53)) ? 48'h0 : 48'hFFFF_FFFF_FFFF;
         if (md == 2'd2) return s[63] ? 48'h8000_0000_0000 : 48'h7FFF_FFFF_FFFF;
         return s[63] ? 48'hFFFF_8000_0000 : 48'h0000_7FFF_FFFF;
      end
      return s[47:0];
   endfunction

   task automatic drive(input bit opv, input logic [1:0] md, input bit omc, input bit rt,
                        input bit sub, input logic [1:0] acc, input logic [31:0] a,
                        input logic [31:0] b, input bit ldv, input logic [1:0] lacc,
                        input logic [47:0] ld, input bit clr, input string tag);
      item_t       it;
      bit          hit, pv, ov;
      logic [63:0] p;
      logic [47:0] nv;
      @(posedge clk);
      #1;
      op_valid = opv; op_mode = md; sat_en = omc; round_en = rt; op_sub = sub;
      op_acc = acc; op_a = a; op_b = b; load_valid = ldv; load_acc = lacc;
      load_data = ld; ovf_clr = clr;
      stat_sel = opv ? acc : lacc;
      hit = opv && !(ldv && lacc == acc);
      ov  = 1'b0;
      if (hit) begin
         p  = m_prod(md, a, b, omc, rt, pv);
         nv = m_sat(md, m_acc[acc], p, sub, omc, pv, ov);
         m_acc[acc] = nv;
         if (ov) m_pav[acc] = 1'b1;
      end
      m_ovf = (m_ovf && !clr) || (hit && ov);
      if (ldv) begin
         m_acc[lacc] = ld;
         m_pav[lacc] = 1'b0;
      end
      it.due  = cyc + 1;
      it.tag  = tag;
      it.flat = {m_acc[3], m_acc[2], m_acc[1], m_acc[0]};
      it.pav  = m_pav;
      it.ovf  = m_ovf;
      sb_q.push_back(it);
   endtask

   task automatic op(input logic [1:0] md, input bit omc, input bit rt, input bit sub,
                     input logic [1:0] acc, input logic [31:0] a, input logic [31:0] b,
                     input string tag);
      drive(1, md, omc, rt, sub, acc, a, b, 0, 2'd0, 48'h0, 0, tag);
   endtask

   task automatic load(input logic [1:0] acc, input logic [47:0] d, input string tag);
      drive(0, 2'd0, 0, 0, 0, 2'd0, 32'h0, 32'h0, 1, acc, d, 0, tag);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [191:0] got,
                      input logic [191:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // Monitor: pops scoreboard items in the cycle they fall due
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
         item_t       it;
         logic [47:0] sa;
         it = sb_q.pop_front();
         sa = it.flat[stat_sel*48 +: 48];
         chk(acc_flat === it.flat, {it.tag, " acc_flat"}, acc_flat, it.flat);
         chk(pav === it.pav, {it.tag, " pav"}, 192'(pav), 192'(it.pav));
         chk(ovf === it.ovf, {it.tag, " ovf"}, 192'(ovf), 192'(it.ovf));
         // R10: status for the selected accumulator
         chk({st_zero, st_neg, st_ovf} === {sa == 0, sa[47], it.pav[stat_sel]},
             {it.tag, " R10 status"}, 192'({st_zero, st_neg, st_ovf}),
             192'({sa == 0, sa[47], it.pav[stat_sel]}));
      end
   end

   initial begin
      #(8 * 60000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) m_acc[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(acc_flat === '0, "R11 reset acc", acc_flat, '0);
      chk({pav, ovf, st_zero} === 6'b000001, "R11 reset flags",
          192'({pav, ovf, st_zero}), 192'(6'b000001));

      op(2'd0, 0, 0, 0, 2'd0, 32'd3, -32'sd5, "R1 R4 signed add");
      op(2'd0, 0, 0, 1, 2'd0, 32'd7, 32'd6, "R4 signed subtract");
      op(2'd1, 0, 0, 0, 2'd1, 32'hFFFF_FFFF, 32'd2, "R2 unsigned fits");
      op(2'd1, 0, 0, 0, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 R8 unsigned truncate");
      drive(0, 2'd0, 0, 0, 0, 2'd0, 0, 0, 1, 2'd1, 48'd5, 1, "R9 R8 load and clear");
      op(2'd1, 1, 0, 0, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 R7 unsigned force clamp max");
      load(2'd1, 48'd5, "R9 reload");
      op(2'd1, 1, 0, 1, 2'd1, 32'd7, 32'd1, "R7 unsigned underflow to zero");
      op(2'd1, 0, 0, 1, 2'd1, 32'd1, 32'd1, "R7 unsigned wrap low bits");
      load(2'd0, 48'd0, "R9 reload acc0");
      op(2'd0, 1, 0, 0, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R1 R5 signed clamp positive");
      load(2'd0, 48'd0, "R9 reload acc0 again");
      op(2'd0, 1, 0, 0, 2'd0, 32'h7FFF_FFFF, 32'h8000_0000, "R1 R5 signed clamp negative");
      load(2'd2, 48'h7FFF_FFFF_FFFF, "R9 load acc2 max");
      op(2'd0, 0, 0, 0, 2'd2, 32'd1, 32'd1, "R5 R10 signed wrap no sat");
      load(2'd3, 48'd0, "R9 load acc3");
      op(2'd2, 0, 1, 0, 2'd3, 32'h0080_0000, 32'd1, "R3 half to even stays");
      op(2'd2, 0, 1, 0, 2'd3, 32'h0180_0000, 32'd1, "R3 half odd rounds up");
      op(2'd2, 0, 0, 0, 2'd3, 32'h0180_0000, 32'd1, "R3 no rounding truncates");
      op(2'd2, 0, 1, 0, 2'd3, 32'h0080_0001, 32'd1, "R3 above half rounds up");
      op(2'd2, 0, 1, 0, 2'd3, 32'hFFFF_FFFF, 32'd1, "R3 negative rounding");
      load(2'd3, 48'h7FFF_FFFF_FFFF, "R9 load acc3 max");
      op(2'd2, 1, 0, 0, 2'd3, 32'h0100_0000, 32'd1, "R6 frac clamp positive");
      load(2'd3, 48'h8000_0000_0000, "R9 load acc3 min");
      op(2'd2, 1, 0, 1, 2'd3, 32'h0100_0000, 32'd1, "R6 frac clamp negative");
      drive(1, 2'd0, 0, 0, 0, 2'd2, 32'd9, 32'd9, 1, 2'd2, 48'd77, 0, "R9 load beats op");
      drive(1, 2'd0, 0, 0, 0, 2'd0, 32'd2, 32'd3, 1, 2'd1, 48'd11, 0, "R9 load other acc");
      drive(1, 2'd1, 1, 0, 0, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2'd0, 0, 1,
            "R8 overflow beats clear");
      drive(0, 2'd0, 0, 0, 0, 2'd0, 0, 0, 0, 2'd0, 0, 1, "R8 clear alone");
      drive(0, 2'd0, 0, 0, 0, 2'd0, 0, 0, 0, 2'd2, 0, 0, "R12 idle keeps state");
      drive(0, 2'd0, 0, 0, 0, 2'd0, 0, 0, 0, 2'd3, 0, 0, "R12 R10 idle status");
      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule